// File: doc/BRIEF.md
# Segmented Multi-Pass Left Shifter

This block performs a logical left shift over several clock cycles. It does not build a full barrel shifter. Instead it reuses two small fixed-distance shifters, one coarse and one fine, which are chained in series. With the default parameters the coarse shifter moves the operand by 4 bits per pass and the fine shifter moves it by 1 bit per pass. Each fixed shifter is only wiring: it drops the top bits and fills the low end with zeros. Each one can also be bypassed, so in that cycle its input passes through unchanged.

A start strobe loads two things. The result register takes the operand. The pass counter takes the shift amount, split into two segments: the upper amount bits give the number of coarse passes and the lower bits give the number of fine passes. In every following cycle with work left, both shifters apply one pass each, and any shifter whose segment is zero is bypassed. The number of cycles therefore equals the larger of the two segment values, not the raw amount.

Start and ready are plain control pins, with no back-pressure. The caller may raise start in any cycle. A new start always wins over an operation still in progress. The result is valid in every cycle in which ready is 1.

Top module: `pass_shifter`

## Requirements
- R1: Once ready returns to 1 after a start, result equals the operand shifted left by the amount, with zero fill and truncation to the data width, for every amount from 0 to 15.
- R2: A start seen at a rising edge makes result equal to the operand in the following cycle. Amount bits [3:2] give the number of 4-bit passes and bits [1:0] give the number of 1-bit passes.
- R3: Ready is 1 exactly when no passes remain. After a start with a nonzero amount, ready is 0 in the following cycle.
- R4: In each cycle with passes left, the 4-bit shift is applied first and then the 1-bit shift. A stage is bypassed when its segment is zero, and each nonzero segment drops by one. Ready returns max(amount[3:2], amount[1:0]) cycles after the loading edge.
- R5: A start with amount 0 keeps ready at 1, and result equals the operand in the next cycle.
- R6: A start issued while an operation is in progress abandons that operation. It reloads the result and the segments from the new inputs.
- R7: While ready is 1 and start is 0, result and ready hold their values.
- R8: The synchronous reset clears result to zero and leaves ready at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load strobe; takes priority over passes in flight |
| operand | input | WIDTH (16) | Value to be shifted |
| amount | input | WIDTH_LG (4) | Shift distance |
| result | output | WIDTH (16) | Registered shifted value |
| ready | output | 1 | High when no passes remain |

## Verification
The bench builds the block with its defaults: a width-log of 4, which gives 16 data bits and a 4-bit amount, and a segment split of 2, which gives a 4-bit coarse shifter and a 1-bit fine shifter. At that size the full range of amounts, 0 through 15, can be covered exhaustively. This includes the cases where only one segment is nonzero and the cases where bits shift past the top of the word. The latency for each of them is compared against the larger segment. A restart issued in the middle of a 15-bit shift, where both segments are busy, shows that the abort works.

// File: rtl/pass_shift_pkg.sv
package pass_shift_pkg;
  // Split point between coarse-pass and fine-pass segments of the amount.
  localparam int DEFAULT_WIDTH_LG = 4;
  localparam int DEFAULT_SPLIT    = 2;

  function automatic int larger_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pass_stage.sv
// One fixed-distance left shifter that can be bypassed. Pure wiring plus a mux.
module pass_stage #(
  parameter int W    = 16,
  parameter int DIST = 1
) (
  input  logic [W-1:0] din,
  input  logic         en,
  output logic [W-1:0] dout
);
  logic [W-1:0] moved;

  generate
    if (DIST >= W) begin : g_all_out
      assign moved = '0;
    end else if (DIST == 0) begin : g_none
      assign moved = din;
    end else begin : g_wire
      assign moved = {din[W-1-DIST:0], {DIST{1'b0}}};
    end
  endgenerate

  assign dout = en ? moved : din;
endmodule

// File: rtl/seg_counter.sv
// Remaining-pass counter for one shifter segment.
module seg_counter #(
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [SW-1:0] load_val,
  output logic [SW-1:0] left,
  output logic          busy
);
  assign busy = |left;

  always_ff @(posedge clk) begin
    if (rst)       left <= '0;
    else if (load) left <= load_val;
    else if (busy) left <= left - 1'b1;
  end
endmodule

// File: rtl/pass_shifter.sv
module pass_shifter
  import pass_shift_pkg::*;
#(
  parameter int WIDTH_LG = DEFAULT_WIDTH_LG,
  parameter int SPLIT    = DEFAULT_SPLIT,
  localparam int WIDTH   = 1 << WIDTH_LG
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [WIDTH-1:0]    operand,
  input  logic [WIDTH_LG-1:0] amount,
  output logic [WIDTH-1:0]    result,
  output logic                ready
);
  localparam int AMT_W  = WIDTH_LG;
  localparam int HI_W   = AMT_W - SPLIT;
  localparam int COARSE = 1 << SPLIT;

  logic [HI_W-1:0]  hi_left;
  logic [SPLIT-1:0] lo_left;
  logic             hi_busy, lo_busy, active;
  logic [WIDTH-1:0] coarse_out, fine_out;

  seg_counter #(.SW(HI_W)) u_hi_seg (
    .clk(clk), .rst(rst), .load(start),
    .load_val(amount[AMT_W-1:SPLIT]),
    .left(hi_left), .busy(hi_busy)
  );

  seg_counter #(.SW(SPLIT)) u_lo_seg (
    .clk(clk), .rst(rst), .load(start),
    .load_val(amount[SPLIT-1:0]),
    .left(lo_left), .busy(lo_busy)
  );

  pass_stage #(.W(WIDTH), .DIST(COARSE)) u_coarse (
    .din(result), .en(hi_busy), .dout(coarse_out)
  );

  pass_stage #(.W(WIDTH), .DIST(1)) u_fine (
    .din(coarse_out), .en(lo_busy), .dout(fine_out)
  );

  assign active = hi_busy | lo_busy;
  assign ready  = ~active;

  always_ff @(posedge clk) begin
    if (rst)         result <= '0;
    else if (start)  result <= operand;
    else if (active) result <= fine_out;
  end
endmodule

// File: rtl/pass_shifter_chk.sv
module pass_shifter_chk #(
  parameter int WIDTH_LG = 4,
  localparam int WIDTH   = 1 << WIDTH_LG
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic [WIDTH-1:0]    operand,
  input logic [WIDTH_LG-1:0] amount,
  input logic [WIDTH-1:0]    result,
  input logic                ready
);
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> result == $past(operand));

  p_busy_falls_r3: assert property (@(posedge clk) disable iff (rst)
    (start && amount != '0) |=> !ready);

  p_zero_amount_r5: assert property (@(posedge clk) disable iff (rst)
    (start && amount == '0) |=> ready);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (ready && !start) |=> (ready && $stable(result)));

  p_reset_state_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ready && result == '0));
endmodule

bind pass_shifter pass_shifter_chk #(.WIDTH_LG(WIDTH_LG)) u_chk (
  .clk(clk), .rst(rst), .start(start), .operand(operand),
  .amount(amount), .result(result), .ready(ready)
);

// File: tb/test_pass_shifter.sv
module test_pass_shifter;
  localparam int WL = 4;
  localparam int W  = 1 << WL;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  operand = '0;
  logic [WL-1:0] amount = '0;
  logic [W-1:0]  result;
  logic          ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state: value and remaining coarse / fine passes.
  logic [W-1:0] m_res = '0;
  int m_hi = 0;
  int m_lo = 0;

  always #2 clk = ~clk;

  pass_shifter #(.WIDTH_LG(WL)) i_pass_shifter (
    .clk(clk), .rst(rst), .start(start), .operand(operand),
    .amount(amount), .result(result), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Behavioural cycle model compared every clock (R4 pass order, R2 load, R8 reset).
  always @(posedge clk) begin
    if (rst) begin
      m_res = '0; m_hi = 0; m_lo = 0;
    end else if (start) begin
      m_res = operand; m_hi = int'(amount) / 4; m_lo = int'(amount) % 4;
    end else if (m_hi > 0 || m_lo > 0) begin
      if (m_hi > 0) begin m_res = m_res << 4; m_hi--; end
      if (m_lo > 0) begin m_res = m_res << 1; m_lo--; end
    end
    #1;
    check(result == m_res, "R4 per-cycle result", int'(result), int'(m_res));
    check(ready == (m_hi == 0 && m_lo == 0), "R3 per-cycle ready", int'(ready),
          int'(m_hi == 0 && m_lo == 0));
  end

  task automatic run_op(input logic [W-1:0] op, input int amt);
    int cyc;
    int mx;
    logic [W-1:0] exp;
    mx  = ((amt / 4) > (amt % 4)) ? (amt / 4) : (amt % 4);
    exp = op << amt;
    @(negedge clk);
    start = 1'b1; operand = op; amount = amt[WL-1:0];
    @(negedge clk);
    start = 1'b0;
    check(result == op, "R2 load", int'(result), int'(op));
    if (amt == 0) check(ready == 1'b1, "R5 zero amount ready", int'(ready), 1);
    else          check(ready == 1'b0, "R3 ready falls", int'(ready), 0);
    cyc = 1;
    while (!ready && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == mx + 1, "R4 latency", cyc - 1, mx);
    check(result == exp, "R1 final result", int'(result), int'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(result == '0, "R8 reset result", int'(result), 0);
    check(ready == 1'b1, "R8 reset ready", int'(ready), 1);
    rst = 1'b0;

    for (int a = 0; a < 16; a++) run_op(16'hB5C3, a);
    for (int a = 0; a < 16; a++) run_op(16'h8001, a);
    run_op(16'hFFFF, 0);

    // R7: idle hold with inputs changing.
    operand = 16'h1234; amount = 4'd9;
    repeat (4) @(negedge clk);
    check(result == (16'hFFFF), "R7 idle hold", int'(result), 16'hFFFF);
    check(ready == 1'b1, "R7 idle ready", int'(ready), 1);

    // R6: restart mid-operation.
    @(negedge clk);
    start = 1'b1; operand = 16'h0F0F; amount = 4'd15;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(ready == 1'b0, "R6 busy before restart", int'(ready), 0);
    run_op(16'h00A5, 5);
    check(result == 16'h14A0, "R6 restart result", int'(result), 16'h14A0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule